// File: doc/BRIEF.md
# Queued-Transaction Display Channel I2C Master

This block is an I2C master for a display data channel link. A host lays out up to four transactions in a shared byte buffer and in a small bank of transaction slots. A single launch pulse then runs them back to back. Each slot gives a byte count, a direction, and flags that decide whether a START condition comes before the slot and a STOP condition after it. Slots without a STOP flag therefore chain into repeated starts.

For every slot the engine first sends the address byte found at the running buffer position. On a write it then sends the payload bytes that follow that byte. On a read it stores the received bytes into the positions that follow it. The engine records a NACK flag for each slot. It raises a completion flag that drives an interrupt through a mask and is cleared by an acknowledge pulse. The bus runs on open-drain pull-low outputs, and a prescale value sets the bit period.

Top module: `ddc_master`

## Requirements
- R1: After reset `busy`, `done_flag`, `irq` and `nack_status` are 0, and both `scl_low` and `sda_low` are 0 (lines released).
- R2: A `go` pulse while idle runs slots 0 to `last_txn` in order. The buffer position starts at 0. Each slot sends the byte at the current position as its address byte (bit 0 = 1 for a read), then a write slot sends the next `count` bytes. The position advances past the address byte and the `count` data positions.
- R3: A slot with its start flag set begins with a START condition. A slot with its stop flag set ends with a STOP condition. A slot without a STOP followed by one with a START produces a repeated start.
- R4: A read slot stores its `count` received bytes at the positions directly after its address byte. The master ACKs (SDA low) every received byte except the last, which it NACKs (SDA released).
- R5: A NACK on an address or write byte of slot i sets bit i of `nack_status`, ends the transfer at once with a STOP, skips all remaining slots and still sets `done_flag`. A new launch clears `nack_status`.
- R6: `done_flag` is set when a run ends. `irq` equals `done_flag` AND `done_mask`, registered (one cycle after a mask change). A `done_ack` pulse clears `done_flag`.
- R7: `stat_clr` clears `done_flag` and `nack_status`. `soft_rst` also stops any run, so that one cycle later `busy` is 0 and both lines are released.
- R8: A `go` pulse while `busy` is 1 is ignored: the running list is neither restarted nor extended.
- R9: Within a byte, consecutive SCL rising edges are 4*(`prescale`+1)+2 clock cycles apart. SDA only changes while SCL is low, except inside START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Aborts the engine and clears status |
| stat_clr | input | 1 | Clears done flag and NACK flags |
| go | input | 1 | Launch pulse, accepted only while idle |
| last_txn | input | 2 | Index of the last slot to run (count minus one) |
| prescale | input | 8 | Bit phase length minus one, in clocks |
| slot_we | input | 1 | Writes one transaction slot |
| slot_sel | input | 2 | Slot to write |
| slot_cnt | input | 4 | Data byte count for the slot |
| slot_rd | input | 1 | 1 = read slot, 0 = write slot |
| slot_start | input | 1 | Issue START before the slot |
| slot_stop | input | 1 | Issue STOP after the slot |
| buf_we | input | 1 | Host buffer write, ignored while busy |
| buf_waddr | input | 4 | Host buffer write position |
| buf_wdata | input | 8 | Host buffer write byte |
| buf_raddr | input | 4 | Host buffer read position |
| buf_rdata | output | 8 | Host buffer read byte, one cycle after address |
| done_mask | input | 1 | Interrupt enable for the done flag |
| done_ack | input | 1 | Clears the done flag |
| busy | output | 1 | A run is in progress |
| done_flag | output | 1 | Run completed |
| irq | output | 1 | Masked done interrupt |
| nack_status | output | 4 | Per-slot NACK flags |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A wrong buffer pointer shows up at the bus within one byte. The bus model logs a wrong address or payload byte, and the buffer read-back after a read slot returns bytes at shifted positions. A wrong slot index or lost abort shows up as extra START or STOP counts and a NACK bit in the wrong position, which are visible as soon as the run ends. A wrong bit-phase counter moves the spacing of SCL rising edges in the first byte. A broken completion path shows up as an `irq` that disagrees with `done_flag` and the mask in the cycle after the change.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  typedef enum logic [1:0] {BC_START, BC_STOP, BC_BIT} bcmd_e;

  // returns {scl_low, sda_low} for a command phase
  function automatic logic [1:0] bus_levels(bcmd_e c, logic b, logic [1:0] ph);
    logic [1:0] r;
    case (c)
      BC_START: case (ph)
        2'd0: r = 2'b10;
        2'd1: r = 2'b00;
        2'd2: r = 2'b01;
        default: r = 2'b11;
      endcase
      BC_STOP: case (ph)
        2'd0: r = 2'b11;
        2'd1: r = 2'b01;
        default: r = 2'b00;
      endcase
      default: r = {(ph == 2'd0) || (ph == 2'd3), ~b};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ddc_buf.sv
module ddc_buf #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_b
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_a <= mem[ra_a];
    rd_b <= mem[ra_b];
  end
endmodule

// File: rtl/ddc_bitio.sv
module ddc_bitio import ddc_pkg::*; #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] prescale,
  input  logic             cmd_go,
  input  bcmd_e            cmd,
  input  logic             cmd_bit,
  input  logic             sda_in,
  output logic             done,
  output logic             rx_bit,
  output logic             scl_low,
  output logic             sda_low,
  output logic             bit_active
);
  logic             active;
  logic [1:0]       phase;
  logic [PRE_W-1:0] cnt;
  bcmd_e            cmd_q;
  logic             bit_q;
  logic             tick;

  assign tick       = active && (cnt == prescale);
  assign bit_active = active && (cmd_q == BC_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      phase   <= 2'd0;
      cnt     <= '0;
      cmd_q   <= BC_STOP;
      bit_q   <= 1'b1;
      done    <= 1'b0;
      rx_bit  <= 1'b1;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (cmd_go) begin
          active <= 1'b1;
          cmd_q  <= cmd;
          bit_q  <= cmd_bit;
          phase  <= 2'd0;
          cnt    <= '0;
        end
      end else begin
        {scl_low, sda_low} <= bus_levels(cmd_q, bit_q, phase);
        if (tick) begin
          cnt   <= '0;
          phase <= phase + 2'd1;
          if (phase == 2'd2) rx_bit <= sda_in;
          if (phase == 2'd3) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ddc_seq.sv
module ddc_seq import ddc_pkg::*; #(
  parameter int NSLOT = 4,
  parameter int CNT_W = 4,
  parameter int AW    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  input  logic [$clog2(NSLOT)-1:0] last_in,
  output logic [$clog2(NSLOT)-1:0] idx,
  input  logic [CNT_W-1:0]         cur_cnt,
  input  logic                     cur_rd,
  input  logic                     cur_start,
  input  logic                     cur_stop,
  output logic [AW-1:0]            ptr,
  input  logic [7:0]               buf_rdata,
  output logic                     buf_we,
  output logic [7:0]               buf_wdata,
  output logic                     cmd_go,
  output bcmd_e                    cmd,
  output logic                     cmd_bit,
  input  logic                     bit_done,
  input  logic                     rx_bit,
  output logic                     busy,
  output logic                     nack_set,
  output logic                     done_set
);
  localparam int IDX_W = $clog2(NSLOT);

  typedef enum logic [3:0] {
    S_IDLE, S_SLOT, S_PREP, S_FETCH, S_START, S_BITS,
    S_STORE, S_END, S_STOP, S_NEXT, S_DONE
  } st_e;

  st_e              st;
  logic [IDX_W-1:0] last;
  logic [CNT_W-1:0] left, nxt_left;
  logic             is_addr, waiting, abort;
  logic [7:0]       shreg, rxb;
  logic [3:0]       bitn;
  logic             byte_end, out_byte;

  assign busy      = (st != S_IDLE);
  assign cmd_go    = (st == S_START || st == S_BITS || st == S_STOP) && !waiting;
  assign cmd       = (st == S_START) ? BC_START : (st == S_STOP) ? BC_STOP : BC_BIT;
  assign out_byte  = is_addr || !cur_rd;
  assign cmd_bit   = (bitn == 4'd8) ? (out_byte || (left == CNT_W'(1))) : shreg[7];
  assign buf_we    = (st == S_STORE);
  assign buf_wdata = rxb;
  assign byte_end  = (st == S_BITS) && bit_done && (bitn == 4'd8);
  assign nack_set  = byte_end && out_byte && rx_bit;
  assign done_set  = (st == S_DONE);
  assign nxt_left  = is_addr ? left : left - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      idx     <= '0;
      last    <= '0;
      ptr     <= '0;
      left    <= '0;
      is_addr <= 1'b0;
      waiting <= 1'b0;
      abort   <= 1'b0;
      shreg   <= 8'hFF;
      rxb     <= 8'h00;
      bitn    <= 4'd0;
    end else begin
      if (cmd_go) waiting <= 1'b1;
      if (bit_done) waiting <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          idx   <= '0;
          last  <= last_in;
          ptr   <= '0;
          abort <= 1'b0;
          st    <= S_SLOT;
        end
        S_SLOT: begin
          left    <= cur_cnt;
          is_addr <= 1'b1;
          st      <= S_FETCH;
        end
        S_PREP: st <= S_FETCH;
        S_FETCH: begin
          shreg <= buf_rdata;
          bitn  <= 4'd0;
          st    <= (is_addr && cur_start) ? S_START : S_BITS;
        end
        S_START: if (bit_done) st <= S_BITS;
        S_BITS: if (bit_done) begin
          if (bitn != 4'd8) begin
            rxb   <= {rxb[6:0], rx_bit};
            shreg <= {shreg[6:0], 1'b1};
            bitn  <= bitn + 4'd1;
          end else begin
            bitn <= 4'd0;
            if (out_byte) begin
              if (rx_bit) begin
                abort <= 1'b1;
                st    <= S_STOP;
              end else begin
                ptr     <= ptr + 1'b1;
                is_addr <= 1'b0;
                left    <= nxt_left;
                shreg   <= 8'hFF;
                if (nxt_left == '0) st <= S_END;
                else if (cur_rd)    st <= S_BITS;
                else                st <= S_PREP;
              end
            end else begin
              st <= S_STORE;
            end
          end
        end
        S_STORE: begin
          ptr   <= ptr + 1'b1;
          left  <= left - 1'b1;
          shreg <= 8'hFF;
          st    <= (left == CNT_W'(1)) ? S_END : S_BITS;
        end
        S_END:  st <= cur_stop ? S_STOP : S_NEXT;
        S_STOP: if (bit_done) st <= abort ? S_DONE : S_NEXT;
        S_NEXT: begin
          if (idx == last) st <= S_DONE;
          else begin
            idx <= idx + 1'b1;
            st  <= S_SLOT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddc_master.sv
module ddc_master import ddc_pkg::*; #(
  parameter int NSLOT     = 4,
  parameter int CNT_W     = 4,
  parameter int BUF_DEPTH = 16,
  parameter int PRE_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         soft_rst,
  input  logic                         stat_clr,
  input  logic                         go,
  input  logic [$clog2(NSLOT)-1:0]     last_txn,
  input  logic [PRE_W-1:0]             prescale,
  input  logic                         slot_we,
  input  logic [$clog2(NSLOT)-1:0]     slot_sel,
  input  logic [CNT_W-1:0]             slot_cnt,
  input  logic                         slot_rd,
  input  logic                         slot_start,
  input  logic                         slot_stop,
  input  logic                         buf_we,
  input  logic [$clog2(BUF_DEPTH)-1:0] buf_waddr,
  input  logic [7:0]                   buf_wdata,
  input  logic [$clog2(BUF_DEPTH)-1:0] buf_raddr,
  output logic [7:0]                   buf_rdata,
  input  logic                         done_mask,
  input  logic                         done_ack,
  output logic                         busy,
  output logic                         done_flag,
  output logic                         irq,
  output logic [NSLOT-1:0]             nack_status,
  output logic                         scl_low,
  output logic                         sda_low,
  input  logic                         sda_in
);
  localparam int IDX_W = $clog2(NSLOT);
  localparam int AW    = $clog2(BUF_DEPTH);

  logic             eng_rst;
  logic [IDX_W-1:0] cur_idx;
  logic [CNT_W-1:0] s_cnt [NSLOT];
  logic [NSLOT-1:0] s_rd, s_start, s_stop;

  assign eng_rst = rst || soft_rst;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        s_cnt[g]   <= '0;
        s_rd[g]    <= 1'b0;
        s_start[g] <= 1'b0;
        s_stop[g]  <= 1'b0;
      end else if (slot_we && slot_sel == IDX_W'(g)) begin
        s_cnt[g]   <= slot_cnt;
        s_rd[g]    <= slot_rd;
        s_start[g] <= slot_start;
        s_stop[g]  <= slot_stop;
      end
    end
  end

  logic [AW-1:0] ptr;
  logic [7:0]    eng_rdata, eng_wdata;
  logic          eng_we;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;

  assign mem_we    = busy ? eng_we : buf_we;
  assign mem_waddr = busy ? ptr : buf_waddr;
  assign mem_wdata = busy ? eng_wdata : buf_wdata;

  ddc_buf #(.AW(AW), .DW(8)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .ra_a(ptr), .rd_a(eng_rdata), .ra_b(buf_raddr), .rd_b(buf_rdata)
  );

  logic  cmd_go, cmd_bit, bit_done, rx_bit, bit_on;
  bcmd_e cmd;

  ddc_bitio #(.PRE_W(PRE_W)) u_bit (
    .clk(clk), .rst(eng_rst), .prescale(prescale), .cmd_go(cmd_go),
    .cmd(cmd), .cmd_bit(cmd_bit), .sda_in(sda_in), .done(bit_done),
    .rx_bit(rx_bit), .scl_low(scl_low), .sda_low(sda_low), .bit_active(bit_on)
  );

  logic nack_set, done_set, launch;

  ddc_seq #(.NSLOT(NSLOT), .CNT_W(CNT_W), .AW(AW)) u_seq (
    .clk(clk), .rst(eng_rst), .go(go), .last_in(last_txn), .idx(cur_idx),
    .cur_cnt(s_cnt[cur_idx]), .cur_rd(s_rd[cur_idx]),
    .cur_start(s_start[cur_idx]), .cur_stop(s_stop[cur_idx]),
    .ptr(ptr), .buf_rdata(eng_rdata), .buf_we(eng_we), .buf_wdata(eng_wdata),
    .cmd_go(cmd_go), .cmd(cmd), .cmd_bit(cmd_bit), .bit_done(bit_done),
    .rx_bit(rx_bit), .busy(busy), .nack_set(nack_set), .done_set(done_set)
  );

  assign launch = go && !busy;

  logic done_d;
  always_comb begin
    done_d = done_flag;
    if (soft_rst || stat_clr) done_d = 1'b0;
    else if (done_set)        done_d = 1'b1;
    else if (done_ack)        done_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_flag   <= 1'b0;
      irq         <= 1'b0;
      nack_status <= '0;
    end else begin
      done_flag <= done_d;
      irq       <= done_d && done_mask;
      if (soft_rst || stat_clr || launch) nack_status <= '0;
      else if (nack_set) nack_status[cur_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/ddc_master_chk.sv
module ddc_master_chk #(
  parameter int NSLOT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             soft_rst,
  input logic             busy,
  input logic             done_flag,
  input logic             done_ack,
  input logic             irq,
  input logic [NSLOT-1:0] nack_status,
  input logic             scl_low,
  input logic             sda_low,
  input logic             bit_active
);
  // R7
  soft_idle_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!busy && !scl_low && !sda_low));

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_flag);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done_ack && !busy) |=> !done_flag);

  // R6
  done_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(busy));

  // R5
  single_nack_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(nack_status));

  // R9
  sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_active && !scl_low && $past(!scl_low)) |-> $stable(sda_low));
endmodule

bind ddc_master ddc_master_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .busy(busy),
  .done_flag(done_flag), .done_ack(done_ack), .irq(irq),
  .nack_status(nack_status), .scl_low(scl_low), .sda_low(sda_low),
  .bit_active(bit_on)
);

// File: tb/ddc_master_tb.sv
module ddc_master_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic soft_rst = 0, stat_clr = 0, go = 0;
  logic [1:0] last_txn = 0;
  logic [7:0] prescale = 8'd2;
  logic slot_we = 0;
  logic [1:0] slot_sel = 0;
  logic [3:0] slot_cnt = 0;
  logic slot_rd = 0, slot_start = 0, slot_stop = 0;
  logic buf_we = 0;
  logic [3:0] buf_waddr = 0, buf_raddr = 0;
  logic [7:0] buf_wdata = 0, buf_rdata;
  logic done_mask = 1, done_ack = 0;
  logic busy, done_flag, irq;
  logic [3:0] nack_status;
  logic scl_low, sda_low, sda_in;
  logic slv_low = 0;

  assign sda_in = !(sda_low || slv_low);

  always #10 clk = ~clk;

  ddc_master u_dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .stat_clr(stat_clr), .go(go),
    .last_txn(last_txn), .prescale(prescale), .slot_we(slot_we),
    .slot_sel(slot_sel), .slot_cnt(slot_cnt), .slot_rd(slot_rd),
    .slot_start(slot_start), .slot_stop(slot_stop), .buf_we(buf_we),
    .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .buf_raddr(buf_raddr),
    .buf_rdata(buf_rdata), .done_mask(done_mask), .done_ack(done_ack),
    .busy(busy), .done_flag(done_flag), .irq(irq), .nack_status(nack_status),
    .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_in)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc++;

  // bus slave model: address 7'h50, NACKs data byte 8'hEE, returns 8'h5A upward
  int phase = 0, bitn = 0, starts = 0, stops = 0, wcount = 0, rcount = 0;
  int rd_ptr = 0, nrise = 0;
  int rise_t [64];
  logic [7:0] byt = 0, tx = 0, wlog [32];
  logic mack [32];
  logic acked = 0, p_scl = 1, p_sda = 1, scl_v, sda_v;

  always @(negedge clk) begin
    scl_v = !scl_low;
    sda_v = sda_in;
    if (p_scl && scl_v && p_sda && !sda_v) begin
      starts++; phase = 1; bitn = 0; byt = 0; slv_low = 0;
    end else if (p_scl && scl_v && !p_sda && sda_v) begin
      stops++; phase = 0; slv_low = 0;
    end else if (scl_v && !p_scl) begin
      if (nrise < 64) rise_t[nrise] = cyc;
      nrise++;
      if (phase >= 1 && phase <= 3) begin
        if (bitn < 8 && phase != 3) byt = {byt[6:0], sda_v};
        if (bitn == 8 && phase == 3) begin
          mack[rcount] = sda_v; rcount++;
          if (sda_v) phase = 4;
        end
        bitn++;
      end
    end else if (!scl_v && p_scl && phase != 0) begin
      if (bitn == 9) begin
        bitn = 0; slv_low = 0;
        if (phase == 1) begin
          if (!acked) phase = 4;
          else if (byt[0]) begin
            phase = 3; tx = 8'h5A + 8'(rd_ptr); rd_ptr++; slv_low = !tx[7];
          end else phase = 2;
        end else if (phase == 2) begin
          if (!acked) phase = 4;
        end else if (phase == 3) begin
          tx = 8'h5A + 8'(rd_ptr); rd_ptr++; slv_low = !tx[7];
        end
      end else if (bitn == 8) begin
        if (phase == 3) slv_low = 0;
        else if (phase != 4) begin
          wlog[wcount] = byt; wcount++;
          acked = (phase == 1) ? (byt[7:1] == 7'h50) : (byt != 8'hEE);
          slv_low = acked;
        end
      end else if (phase == 3 && bitn < 8) begin
        slv_low = !tx[7 - bitn];
      end
    end
    p_scl = scl_v;
    p_sda = sda_v;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slave_clear();
    phase = 0; bitn = 0; starts = 0; stops = 0; wcount = 0; rcount = 0;
    rd_ptr = 0; nrise = 0; slv_low = 0;
  endtask

  task automatic put(input int a, input logic [7:0] d);
    @(negedge clk); buf_we = 1; buf_waddr = 4'(a); buf_wdata = d;
    @(negedge clk); buf_we = 0;
  endtask

  task automatic get(input int a, output logic [7:0] d);
    @(negedge clk); buf_raddr = 4'(a);
    @(negedge clk); d = buf_rdata;
  endtask

  task automatic slot(input int i, input int cnt, input logic rd, input logic st, input logic sp);
    @(negedge clk);
    slot_we = 1; slot_sel = 2'(i); slot_cnt = 4'(cnt);
    slot_rd = rd; slot_start = st; slot_stop = sp;
    @(negedge clk); slot_we = 0;
  endtask

  task automatic launch(input int last);
    @(negedge clk); go = 1; last_txn = 2'(last);
    @(negedge clk); go = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
  endtask

  task automatic ack_done();
    @(negedge clk); done_ack = 1;
    @(negedge clk); done_ack = 0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 nack", nack_status, 0);
    chk("R1 lines", {scl_low, sda_low}, 0);
  endtask

  task automatic t_write();
    prescale = 8'd2; slave_clear();
    put(0, 8'hA0); put(1, 8'h11); put(2, 8'h22);
    slot(0, 2, 0, 1, 1);
    launch(0); wait_idle();
    chk("R2 bytes", wcount, 3);
    chk("R2 addr", wlog[0], 8'hA0);
    chk("R2 data0", wlog[1], 8'h11);
    chk("R2 data1", wlog[2], 8'h22);
    chk("R3 starts", starts, 1);
    chk("R3 stops", stops, 1);
    chk("R9 period p2", rise_t[2] - rise_t[1], 14);
    chk("R6 done", done_flag, 1);
    chk("R6 irq", irq, 1);
    chk("R5 nack none", nack_status, 0);
    ack_done();
    chk("R6 ack clears done", done_flag, 0);
    chk("R6 ack clears irq", irq, 0);
  endtask

  task automatic t_wr_rd();
    logic [7:0] d;
    prescale = 8'd5; slave_clear();
    put(0, 8'hA0); put(1, 8'h05); put(2, 8'hA1);
    put(3, 8'h00); put(4, 8'h00); put(5, 8'h00); put(6, 8'h99);
    slot(0, 1, 0, 1, 0);
    slot(1, 3, 1, 1, 1);
    launch(1); wait_idle();
    chk("R9 period p5", rise_t[2] - rise_t[1], 26);
    chk("R3 repeated start", starts, 2);
    chk("R3 single stop", stops, 1);
    chk("R2 read addr", wlog[2], 8'hA1);
    get(3, d); chk("R4 rd0", d, 8'h5A);
    get(4, d); chk("R4 rd1", d, 8'h5B);
    get(5, d); chk("R4 rd2", d, 8'h5C);
    get(6, d); chk("R4 beyond untouched", d, 8'h99);
    chk("R4 ack0", mack[0], 0);
    chk("R4 ack1", mack[1], 0);
    chk("R4 nack last", mack[2], 1);
    ack_done();
  endtask

  task automatic t_addr_nack();
    prescale = 8'd2; slave_clear();
    put(0, 8'hA0); put(1, 8'h01); put(2, 8'hA2); put(3, 8'h02);
    put(4, 8'hA0); put(5, 8'h03);
    slot(0, 1, 0, 1, 0); slot(1, 1, 0, 1, 0); slot(2, 1, 0, 1, 1);
    launch(2); wait_idle();
    chk("R5 nack slot1", nack_status, 4'b0010);
    chk("R5 skipped starts", starts, 2);
    chk("R5 abort stop", stops, 1);
    chk("R5 bytes seen", wcount, 3);
    chk("R5 done", done_flag, 1);
    ack_done();
  endtask

  task automatic t_data_nack_mask();
    done_mask = 0; slave_clear();
    put(0, 8'hA0); put(1, 8'h10); put(2, 8'hEE); put(3, 8'h30);
    slot(0, 3, 0, 1, 1);
    launch(0); wait_idle();
    chk("R5 data nack", nack_status, 4'b0001);
    chk("R5 stop after nack", wcount, 3);
    chk("R6 masked done", done_flag, 1);
    chk("R6 masked irq", irq, 0);
    @(negedge clk); done_mask = 1;
    @(negedge clk);
    chk("R6 unmask irq", irq, 1);
    @(negedge clk); stat_clr = 1;
    @(negedge clk); stat_clr = 0;
    chk("R7 clr done", done_flag, 0);
    chk("R7 clr nack", nack_status, 0);
    chk("R7 clr irq", irq, 0);
  endtask

  task automatic t_go_busy();
    slave_clear();
    put(0, 8'hA0); put(1, 8'h11); put(2, 8'h22);
    slot(0, 2, 0, 1, 1); slot(1, 1, 0, 1, 1);
    launch(0);
    repeat (20) @(negedge clk);
    launch(1);
    wait_idle();
    chk("R8 starts", starts, 1);
    chk("R8 bytes", wcount, 3);
    ack_done();
  endtask

  task automatic t_soft();
    slave_clear();
    launch(0);
    repeat (30) @(negedge clk);
    soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    chk("R7 soft busy", busy, 0);
    chk("R7 soft lines", {scl_low, sda_low}, 0);
    chk("R7 soft done", done_flag, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_four();
    logic [7:0] d;
    slave_clear();
    put(0, 8'hA0); put(1, 8'hA1); put(2, 8'h00);
    put(3, 8'hA0); put(4, 8'h77); put(5, 8'hB0);
    slot(0, 0, 0, 1, 0); slot(1, 1, 1, 1, 0);
    slot(2, 1, 0, 1, 0); slot(3, 0, 0, 1, 1);
    launch(3); wait_idle();
    chk("R5 nack slot3", nack_status, 4'b1000);
    chk("R3 four starts", starts, 4);
    chk("R3 one stop", stops, 1);
    get(2, d); chk("R4 single read", d, 8'h5A);
    chk("R4 single nack", mack[0], 1);
    chk("R2 slot2 data", wlog[3], 8'h77);
    ack_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write();
    t_wr_rd();
    t_addr_nack();
    t_data_nack_mask();
    t_go_busy();
    t_soft();
    t_four();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule